// File: doc/BRIEF.md
# Accumulator arithmetic logic unit

This block is the byte datapath of a small accumulator machine. Each cycle in which `op_valid` is high, it takes an operation code and its already selected operands: the accumulator, a second operand, the B register, and the carry and auxiliary-carry flags. One clock later it presents the new accumulator, B and flag values. Each of these comes with its own write-enable, so the surrounding register file updates only what the operation changes.

The operations are add, add with carry, subtract with borrow, increment, decrement, unsigned multiply into the B:A pair, and divide with the quotient in A and the remainder in B. It also does decimal adjust after a packed-BCD addition, AND, OR, XOR, clear, complement and half swap. The rotate forms are left and right, each either around the byte or through the carry. Instruction fetch, decode and operand addressing belong to the surrounding core.

Results are registered. They hold their value until the next accepted operation. An unused opcode still produces a result strobe, with every write-enable low.

Top module: `acc_alu`

## Requirements
- R1: A result appears with `res_valid` high in the cycle after `op_valid` was sampled high. With no operation accepted, `res_valid` and all write-enables are low and `acc_out` holds its value.
- R2: ADD (op_code 0) gives A + operand and ignores `cy_in`. CY is the carry out of bit 7, AC the carry out of bit 3, and OV the signed overflow. It writes A, CY, AC and OV.
- R3: ADDC (op_code 1) gives A + operand + CY, with the same flags and write-enables as ADD.
- R4: SUBB (op_code 2) gives A − operand − CY. CY is the borrow out of bit 7, AC the borrow from bit 3, and OV the signed overflow. It writes A, CY, AC and OV.
- R5: INC (op_code 3) and DEC (op_code 4) give A + 1 and A − 1, wrapping modulo 256. They write only A.
- R6: MUL (op_code 5) puts the 16-bit product A·B with its high byte in B and its low byte in A. It clears CY and sets OV exactly when the product exceeds 255. It writes A, B, CY and OV.
- R7: DIV (op_code 6) puts the quotient A/B in A and the remainder in B, and clears CY and OV. When B is zero it sets OV instead, and the A and B values are not defined. It writes A, B, CY and OV.
- R8: DA (op_code 7) adds 06h when the low nibble exceeds 9 or AC is set. It then adds 60h when the high nibble of that result exceeds 9 or CY is set. CY is set if either addition carries out of bit 7 and is never cleared. It writes A and CY.
- R9: AND, OR and XOR with the operand (op_codes 8, 9, 10), clear to zero (11) and complement (12) write only A.
- R10: SWAP (op_code 13) exchanges bits 3..0 with bits 7..4 of A and writes only A.
- R11: RL (op_code 14) moves bit 7 into bit 0. RR (op_code 16) moves bit 0 into bit 7. Both write only A.
- R12: RLC (op_code 15) shifts CY into bit 0 and bit 7 into CY. RRC (op_code 17) shifts CY into bit 7 and bit 0 into CY. Both write A and CY.
- R13: While `rst_n` is low, every output is zero.

Write-enable bits in the order A, B, CY, AC, OV apply throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 5 | Operation selector |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand |
| b_in | input | 8 | Current B register |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| res_valid | output | 1 | Result strobe |
| acc_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary carry flag |
| ov_out | output | 1 | New overflow flag |
| acc_we | output | 1 | Write accumulator |
| b_we | output | 1 | Write B |
| cy_we | output | 1 | Write carry |
| ac_we | output | 1 | Write auxiliary carry |
| ov_we | output | 1 | Write overflow |

## Verification
The assertions take for granted that `op_valid` stays low until the internal reset has been released. They also assume that the operation code and every operand are known, not X, in each cycle where `op_valid` is high. The divide and multiply checks compare the result against the operands captured with that operation, so both rely on the operands being steady across the accepting edge.

The stimulus keeps to these conditions. It drives all inputs only on the falling edge and waits several cycles after reset before its first operation. It uses only opcodes 0 to 17, and the mixed sequences include divisors of zero and values at the edges of carry and overflow.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_MUL  = 5'd5,
    OP_DIV  = 5'd6,
    OP_DA   = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_CLR  = 5'd11,
    OP_CPL  = 5'd12,
    OP_SWAP = 5'd13,
    OP_RL   = 5'd14,
    OP_RLC  = 5'd15,
    OP_RR   = 5'd16,
    OP_RRC  = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic acc;
    logic b;
    logic cy;
    logic ac;
    logic ov;
  } we_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   o,
  input  logic           cy,
  output logic [W-1:0]   res,
  output logic           cy_o,
  output logic           ac_o,
  output logic           ov_o
);
  localparam int HALF = W / 2;

  logic          sub;
  logic          cin;
  logic [W-1:0]  o_eff;
  logic [W-1:0]  b_op;
  logic          c0;
  logic [W:0]    full;
  logic [HALF:0] lowsum;

  always_comb begin
    sub   = 1'b0;
    cin   = 1'b0;
    o_eff = o;
    case (op)
      OP_ADDC: cin = cy;
      OP_SUBB: begin sub = 1'b1; cin = cy; end
      OP_INC:  o_eff = W'(1);
      OP_DEC:  begin sub = 1'b1; o_eff = W'(1); end
      default: ;
    endcase
    // subtraction as a + ~o + ~borrow_in
    b_op   = sub ? ~o_eff : o_eff;
    c0     = sub ? ~cin : cin;
    full   = {1'b0, a} + {1'b0, b_op} + {{W{1'b0}}, c0};
    lowsum = {1'b0, a[HALF-1:0]} + {1'b0, b_op[HALF-1:0]} + {{HALF{1'b0}}, c0};
    res    = full[W-1:0];
    cy_o   = sub ? ~full[W] : full[W];
    ac_o   = sub ? ~lowsum[HALF] : lowsum[HALF];
    ov_o   = (a[W-1] == b_op[W-1]) && (full[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cy,
  input  logic         ac,
  output logic [W-1:0] res,
  output logic         cy_o
);
  localparam int HALF = W / 2;
  localparam logic [W:0]      SIX_LO = (W+1)'(6);
  localparam logic [W:0]      SIX_HI = SIX_LO << HALF;
  localparam logic [HALF-1:0] NINE   = HALF'(9);

  logic [W:0] t1;
  logic [W:0] t2;
  logic       c1;

  always_comb begin
    t1 = {1'b0, a};
    if (a[HALF-1:0] > NINE || ac) t1 = t1 + SIX_LO;
    c1 = cy | t1[W];
    t2 = {1'b0, t1[W-1:0]};
    if (t1[W-1:HALF] > NINE || c1) t2 = t2 + SIX_HI;
    cy_o = c1 | t2[W];
    res  = t2[W-1:0];
  end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem
);
  logic [W:0] rem_w;

  assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  // restoring division, one quotient bit per stage
  always_comb begin
    rem_w = '0;
    quo   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      rem_w = {rem_w[W-1:0], a[i]};
      if (rem_w >= {1'b0, b}) begin
        rem_w  = rem_w - {1'b0, b};
        quo[i] = 1'b1;
      end
    end
    rem = rem_w[W-1:0];
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] o,
  input  logic         cy,
  output logic [W-1:0] res,
  output logic         cy_o
);
  localparam int HALF = W / 2;

  always_comb begin
    res  = a;
    cy_o = cy;
    case (op)
      OP_AND:  res = a & o;
      OP_OR:   res = a | o;
      OP_XOR:  res = a ^ o;
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      OP_SWAP: res = {a[HALF-1:0], a[W-1:HALF]};
      OP_RL:   res = {a[W-2:0], a[W-1]};
      OP_RLC:  begin res = {a[W-2:0], cy}; cy_o = a[W-1]; end
      OP_RR:   res = {a[0], a[W-1:1]};
      OP_RRC:  begin res = {cy, a[W-1:1]}; cy_o = a[0]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              cy_in,
  input  logic              ac_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] acc_out,
  output logic [DATA_W-1:0] b_out,
  output logic              cy_out,
  output logic              ac_out,
  output logic              ov_out,
  output logic              acc_we,
  output logic              b_we,
  output logic              cy_we,
  output logic              ac_we,
  output logic              ov_we
);
  localparam int W = DATA_W;

  alu_op_e op_e;
  assign op_e = alu_op_e'(op_code);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic [W-1:0]   as_res;
  logic           as_cy, as_ac, as_ov;
  logic [W-1:0]   da_res;
  logic           da_cy;
  logic [2*W-1:0] md_prod;
  logic [W-1:0]   md_quo, md_rem;
  logic [W-1:0]   bit_res;
  logic           bit_cy;

  alu_addsub #(.W(W)) u_addsub (
    .op(op_e), .a(acc_in), .o(opnd_in), .cy(cy_in),
    .res(as_res), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
  );

  alu_bcd #(.W(W)) u_bcd (
    .a(acc_in), .cy(cy_in), .ac(ac_in), .res(da_res), .cy_o(da_cy)
  );

  alu_muldiv #(.W(W)) u_muldiv (
    .a(acc_in), .b(b_in), .prod(md_prod), .quo(md_quo), .rem(md_rem)
  );

  alu_bitops #(.W(W)) u_bitops (
    .op(op_e), .a(acc_in), .o(opnd_in), .cy(cy_in),
    .res(bit_res), .cy_o(bit_cy)
  );

  // next-state selection
  logic [W-1:0] nxt_acc, nxt_b;
  logic         nxt_cy, nxt_ac, nxt_ov;
  we_t          nxt_we;

  always_comb begin
    nxt_acc = acc_in;
    nxt_b   = b_in;
    nxt_cy  = cy_in;
    nxt_ac  = ac_in;
    nxt_ov  = 1'b0;
    nxt_we  = '0;
    case (op_e)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        nxt_acc = as_res;
        nxt_cy  = as_cy;
        nxt_ac  = as_ac;
        nxt_ov  = as_ov;
        nxt_we  = '{acc: 1'b1, b: 1'b0, cy: 1'b1, ac: 1'b1, ov: 1'b1};
      end
      OP_INC, OP_DEC: begin
        nxt_acc    = as_res;
        nxt_we.acc = 1'b1;
      end
      OP_MUL: begin
        nxt_acc = md_prod[W-1:0];
        nxt_b   = md_prod[2*W-1:W];
        nxt_cy  = 1'b0;
        nxt_ov  = |md_prod[2*W-1:W];
        nxt_we  = '{acc: 1'b1, b: 1'b1, cy: 1'b1, ac: 1'b0, ov: 1'b1};
      end
      OP_DIV: begin
        nxt_acc = md_quo;
        nxt_b   = md_rem;
        nxt_cy  = 1'b0;
        nxt_ov  = (b_in == '0);
        nxt_we  = '{acc: 1'b1, b: 1'b1, cy: 1'b1, ac: 1'b0, ov: 1'b1};
      end
      OP_DA: begin
        nxt_acc    = da_res;
        nxt_cy     = da_cy;
        nxt_we.acc = 1'b1;
        nxt_we.cy  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL, OP_SWAP, OP_RL, OP_RR: begin
        nxt_acc    = bit_res;
        nxt_we.acc = 1'b1;
      end
      OP_RLC, OP_RRC: begin
        nxt_acc    = bit_res;
        nxt_cy     = bit_cy;
        nxt_we.acc = 1'b1;
        nxt_we.cy  = 1'b1;
      end
      default: ;
    endcase
  end

  // registers
  logic [W-1:0] acc_q, b_q;
  logic         cy_q, ac_q, ov_q, valid_q;
  we_t          we_q;
  we_t          we_d;

  assign we_d = op_valid ? nxt_we : '0;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      valid_q <= 1'b0;
      we_q    <= '0;
    end else begin
      valid_q <= op_valid;
      we_q    <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      acc_q <= '0;
      b_q   <= '0;
      cy_q  <= 1'b0;
      ac_q  <= 1'b0;
      ov_q  <= 1'b0;
    end else if (op_valid) begin
      acc_q <= nxt_acc;
      b_q   <= nxt_b;
      cy_q  <= nxt_cy;
      ac_q  <= nxt_ac;
      ov_q  <= nxt_ov;
    end
  end

  assign res_valid = valid_q;
  assign acc_out   = acc_q;
  assign b_out     = b_q;
  assign cy_out    = cy_q;
  assign ac_out    = ac_q;
  assign ov_out    = ov_q;
  assign acc_we    = we_q.acc;
  assign b_we      = we_q.b;
  assign cy_we     = we_q.cy;
  assign ac_we     = we_q.ac;
  assign ov_we     = we_q.ov;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst_q,
  input logic            op_valid,
  input logic [OP_W-1:0] op_code,
  input logic [W-1:0]    acc_in,
  input logic [W-1:0]    opnd_in,
  input logic [W-1:0]    b_in,
  input logic            res_valid,
  input logic [W-1:0]    acc_out,
  input logic [W-1:0]    b_out,
  input logic            cy_out,
  input logic            ov_out,
  input logic            acc_we,
  input logic            b_we,
  input logic            cy_we,
  input logic            ac_we,
  input logic            ov_we
);
  logic [OP_W-1:0] op_s;
  logic [W-1:0]    a_s, o_s, b_s;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      op_s <= '0;
      a_s  <= '0;
      o_s  <= '0;
      b_s  <= '0;
    end else if (op_valid) begin
      op_s <= op_code;
      a_s  <= acc_in;
      o_s  <= opnd_in;
      b_s  <= b_in;
    end
  end

  logic [W:0]     add_ref;
  logic [2*W-1:0] div_back;
  logic           is_logic;
  assign add_ref  = {1'b0, a_s} + {1'b0, o_s};
  assign div_back = {{W{1'b0}}, acc_out} * {{W{1'b0}}, b_s} + {{W{1'b0}}, b_out};
  assign is_logic = (op_s >= OP_AND) && (op_s <= OP_CPL);

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_q)
    op_valid |=> res_valid); // R1

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    !res_valid |-> !(acc_we || b_we || cy_we || ac_we || ov_we)); // R1

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !op_valid |=> $stable(acc_out)); // R1

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_q)
    (res_valid && op_s == OP_ADD) |-> ({cy_out, acc_out} == add_ref)); // R2

  AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (!rst_q)
    (res_valid && op_s == OP_MUL) |-> (cy_we && !cy_out && ov_we && (ov_out == (b_out != '0)))); // R6

  AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_q)
    (res_valid && op_s == OP_DIV && b_s != '0) |-> (div_back == {{W{1'b0}}, a_s} && b_out < b_s && !ov_out && !cy_out)); // R7

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (res_valid && op_s == OP_DIV && b_s == '0) |-> (ov_out && ov_we)); // R7

  AST_LOGIC_WRITES: assert property (@(posedge clk) disable iff (!rst_q)
    (res_valid && is_logic) |-> (acc_we && !b_we && !cy_we && !ac_we && !ov_we)); // R9
endmodule

bind acc_alu acc_alu_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .op_valid(op_valid), .op_code(op_code),
  .acc_in(acc_in), .opnd_in(opnd_in), .b_in(b_in),
  .res_valid(res_valid), .acc_out(acc_out), .b_out(b_out),
  .cy_out(cy_out), .ov_out(ov_out),
  .acc_we(acc_we), .b_we(b_we), .cy_we(cy_we), .ac_we(ac_we), .ov_we(ov_we)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [4:0] op_code;
  logic [7:0] acc_in, opnd_in, b_in;
  logic       cy_in, ac_in;
  logic       res_valid;
  logic [7:0] acc_out, b_out;
  logic       cy_out, ac_out, ov_out;
  logic       acc_we, b_we, cy_we, ac_we, ov_we;

  always #5 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .b_in(b_in), .cy_in(cy_in), .ac_in(ac_in),
    .res_valid(res_valid), .acc_out(acc_out), .b_out(b_out),
    .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out),
    .acc_we(acc_we), .b_we(b_we), .cy_we(cy_we), .ac_we(ac_we), .ov_we(ov_we)
  );

  typedef struct {
    logic [4:0] op;
    logic [7:0] acc;
    logic [7:0] b;
    logic       cy, ac, ov;
    logic [4:0] we;      // acc, b, cy, ac, ov
    logic       chk_ab;
  } exp_t;

  exp_t q[$];
  int   checks   = 0;
  int   failures = 0;
  logic run_mon  = 1'b0;
  logic done     = 1'b0;

  function automatic string req_of(logic [4:0] op);
    case (op)
      5'd0:  return "R2";
      5'd1:  return "R3";
      5'd2:  return "R4";
      5'd3, 5'd4: return "R5";
      5'd5:  return "R6";
      5'd6:  return "R7";
      5'd7:  return "R8";
      5'd13: return "R10";
      5'd14, 5'd16: return "R11";
      5'd15, 5'd17: return "R12";
      default: return "R9";
    endcase
  endfunction

  function automatic exp_t model(logic [4:0] op, logic [7:0] a, logic [7:0] o,
                                 logic [7:0] b, logic c, logic h);
    exp_t e;
    logic [8:0]  s;
    logic [15:0] p;
    int          d, dl;
    logic [7:0]  t;
    logic        cc;
    e.op = op; e.acc = a; e.b = b; e.cy = c; e.ac = h; e.ov = 1'b0;
    e.we = 5'b00000; e.chk_ab = 1'b1;
    case (op)
      5'd0, 5'd1: begin
        cc = (op == 5'd1) ? c : 1'b0;
        s = {1'b0, a} + {1'b0, o} + {8'd0, cc};
        e.acc = s[7:0]; e.cy = s[8];
        e.ac = ({1'b0, a[3:0]} + {1'b0, o[3:0]} + {4'd0, cc}) > 5'd15;
        e.ov = (a[7] == o[7]) && (s[7] != a[7]);
        e.we = 5'b10111;
      end
      5'd2: begin
        d  = int'(a) - int'(o) - int'(c);
        dl = int'(a[3:0]) - int'(o[3:0]) - int'(c);
        e.acc = 8'(d); e.cy = d < 0; e.ac = dl < 0;
        e.ov = (a[7] != o[7]) && (e.acc[7] != a[7]);
        e.we = 5'b10111;
      end
      5'd3: begin e.acc = a + 8'd1; e.we = 5'b10000; end
      5'd4: begin e.acc = a - 8'd1; e.we = 5'b10000; end
      5'd5: begin
        p = {8'd0, a} * {8'd0, b};
        e.acc = p[7:0]; e.b = p[15:8]; e.cy = 1'b0; e.ov = p > 16'd255;
        e.we = 5'b11101;
      end
      5'd6: begin
        e.cy = 1'b0; e.we = 5'b11101;
        if (b == 8'd0) begin e.ov = 1'b1; e.chk_ab = 1'b0; end
        else begin e.acc = a / b; e.b = a % b; e.ov = 1'b0; end
      end
      5'd7: begin
        t = a; cc = c;
        if (a[3:0] > 4'd9 || h) begin
          s = {1'b0, t} + 9'h006; if (s[8]) cc = 1'b1; t = s[7:0];
        end
        if (t[7:4] > 4'd9 || cc) begin
          s = {1'b0, t} + 9'h060; if (s[8]) cc = 1'b1; t = s[7:0];
        end
        e.acc = t; e.cy = cc; e.we = 5'b10100;
      end
      5'd8:  begin e.acc = a & o; e.we = 5'b10000; end
      5'd9:  begin e.acc = a | o; e.we = 5'b10000; end
      5'd10: begin e.acc = a ^ o; e.we = 5'b10000; end
      5'd11: begin e.acc = 8'd0;  e.we = 5'b10000; end
      5'd12: begin e.acc = ~a;    e.we = 5'b10000; end
      5'd13: begin e.acc = {a[3:0], a[7:4]}; e.we = 5'b10000; end
      5'd14: begin e.acc = {a[6:0], a[7]};   e.we = 5'b10000; end
      5'd15: begin e.acc = {a[6:0], c}; e.cy = a[7]; e.we = 5'b10100; end
      5'd16: begin e.acc = {a[0], a[7:1]};   e.we = 5'b10000; end
      5'd17: begin e.acc = {c, a[7:1]}; e.cy = a[0]; e.we = 5'b10100; end
      default: ;
    endcase
    return e;
  endfunction

  // driver: called at a falling edge, returns at the next one
  task automatic drive_op(logic [4:0] op, logic [7:0] a, logic [7:0] o,
                          logic [7:0] b, logic c, logic h);
    op_code = op; acc_in = a; opnd_in = o; b_in = b; cy_in = c; ac_in = h;
    op_valid = 1'b1;
    q.push_back(model(op, a, o, b, c, h));
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (run_mon) begin
      if (res_valid) begin
        checks++;
        if (q.size() == 0) begin
          failures++;
          $display("FAIL R1 unexpected result strobe: actual valid=1 expected valid=0");
        end else begin
          exp_t e;
          logic [4:0] gw;
          logic bad;
          e  = q.pop_front();
          gw = {acc_we, b_we, cy_we, ac_we, ov_we};
          bad = (gw != e.we);
          if (e.we[4] && e.chk_ab && acc_out != e.acc) bad = 1'b1;
          if (e.we[3] && e.chk_ab && b_out != e.b) bad = 1'b1;
          if (e.we[2] && cy_out != e.cy) bad = 1'b1;
          if (e.we[1] && ac_out != e.ac) bad = 1'b1;
          if (e.we[0] && ov_out != e.ov) bad = 1'b1;
          if (bad) begin
            failures++;
            $display("FAIL %s op=%0d actual acc=%h b=%h cy=%b ac=%b ov=%b we=%b expected acc=%h b=%h cy=%b ac=%b ov=%b we=%b",
                     req_of(e.op), e.op, acc_out, b_out, cy_out, ac_out, ov_out, gw,
                     e.acc, e.b, e.cy, e.ac, e.ov, e.we);
          end
        end
      end else begin
        checks++;
        if (acc_we || b_we || cy_we || ac_we || ov_we) begin
          failures++;
          $display("FAIL R1 write-enable while idle: actual we=%b expected we=00000",
                   {acc_we, b_we, cy_we, ac_we, ov_we});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    rst_n = 1'b0; op_valid = 1'b0; op_code = 5'd0;
    acc_in = 8'd0; opnd_in = 8'd0; b_in = 8'd0; cy_in = 1'b0; ac_in = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if ({res_valid, acc_out, b_out, cy_out, ac_out, ov_out, acc_we, b_we, cy_we, ac_we, ov_we} != 27'd0) begin
      failures++;
      $display("FAIL R13 reset outputs: actual valid=%b acc=%h b=%h expected all zero",
               res_valid, acc_out, b_out);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_mon = 1'b1;

    // R2: carry-in ignored, overflow, half carry
    drive_op(5'd0, 8'h7F, 8'h01, 8'h00, 1'b0, 1'b0);
    drive_op(5'd0, 8'h80, 8'h80, 8'h00, 1'b1, 1'b0);
    // R3
    drive_op(5'd1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0);
    drive_op(5'd1, 8'h3A, 8'h05, 8'h00, 1'b1, 1'b0);
    // R4
    drive_op(5'd2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0);
    drive_op(5'd2, 8'h80, 8'h00, 8'h00, 1'b1, 1'b0);
    drive_op(5'd2, 8'h10, 8'h10, 8'h00, 1'b1, 1'b0);
    // R5 wrap
    drive_op(5'd3, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1);
    drive_op(5'd4, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0);
    // R6
    drive_op(5'd5, 8'h10, 8'h00, 8'h10, 1'b1, 1'b0);
    drive_op(5'd5, 8'h03, 8'h00, 8'h04, 1'b1, 1'b0);
    drive_op(5'd5, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0);
    // R7 including zero divisor
    drive_op(5'd6, 8'hFB, 8'h00, 8'h12, 1'b1, 1'b0);
    drive_op(5'd6, 8'h05, 8'h00, 8'h09, 1'b0, 1'b0);
    drive_op(5'd6, 8'h42, 8'h00, 8'h00, 1'b1, 1'b0);
    // R8
    drive_op(5'd7, 8'h81, 8'h00, 8'h00, 1'b0, 1'b1);
    drive_op(5'd7, 8'h9A, 8'h00, 8'h00, 1'b0, 1'b0);
    drive_op(5'd7, 8'h12, 8'h00, 8'h00, 1'b1, 1'b0);
    // R9
    drive_op(5'd8,  8'hF0, 8'h3C, 8'h00, 1'b1, 1'b0);
    drive_op(5'd9,  8'hF0, 8'h0C, 8'h00, 1'b0, 1'b0);
    drive_op(5'd10, 8'hFF, 8'h5A, 8'h00, 1'b0, 1'b0);
    drive_op(5'd11, 8'hA7, 8'h00, 8'h00, 1'b1, 1'b1);
    drive_op(5'd12, 8'h5A, 8'h00, 8'h00, 1'b0, 1'b0);
    // R10
    drive_op(5'd13, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b0);
    // R11
    drive_op(5'd14, 8'h81, 8'h00, 8'h00, 1'b0, 1'b0);
    drive_op(5'd16, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0);
    // R12
    drive_op(5'd15, 8'h80, 8'h00, 8'h00, 1'b0, 1'b0);
    drive_op(5'd17, 8'h01, 8'h00, 8'h00, 1'b1, 1'b0);

    // R1: result held while idle
    drive_op(5'd3, 8'h41, 8'h00, 8'h00, 1'b0, 1'b0);
    held = acc_out;
    repeat (3) @(negedge clk);
    checks++;
    if (acc_out != 8'h42 || held != 8'h42) begin
      failures++;
      $display("FAIL R1 hold after idle: actual acc=%h first=%h expected acc=42", acc_out, held);
    end

    // mixed back-to-back sequence over all opcodes
    for (int i = 0; i < 400; i++) begin
      logic [7:0] bb;
      bb = (i % 17 == 0) ? 8'h00 : 8'($urandom);
      drive_op(5'($urandom_range(0, 17)), 8'($urandom), 8'($urandom), bb,
               1'($urandom), 1'($urandom));
      if (i % 50 == 0) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    run_mon = 1'b0;
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R1 results missing: actual pending=%0d expected 0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule